// File: doc/BRIEF.md
# Base Integer HINT Encoding Classifier

This block looks at one 32-bit base integer instruction per cycle and tells whether the encoding is a HINT. A HINT is a form that a core may retire as an architectural no-op. Each HINT found goes into one of three groups: space held back for future standard use, space left for custom use, and the single spin-wait pause code point. The exact canonical NOP encoding gets a flag of its own.

The front end or decode stage presents an instruction with a qualifier. One clock later the five flags come out of registers. An encoding that is not a HINT and is not the canonical NOP leaves every flag low. The block does not decode ordinary instructions any further. The shift-amount width follows a parameter: with `WIDE_SHAMT` at 0, bit 25 of an immediate shift must be zero (32-bit register file). With it set to 1, bit 25 is part of the shift amount.

Top module: `hint_classifier`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises with no qualified input, all five outputs are 0.
- R2: Each output reflects the instruction that was sampled at the previous rising edge with `in_valid` high. If `in_valid` was low at that edge, all outputs are 0 whatever the instruction bits were.
- R3: An upper-immediate load (opcode bits [6:0] = 0110111) or an add-upper-immediate-to-pc (0010111) whose destination, bits [11:7], is zero sets `hint_std`.
- R4: An immediate add (opcode 0010011, funct3 bits [14:12] = 000) with rd = 0 sets `hint_std` when rs1 (bits [19:15]) is nonzero or the immediate (bits [31:20]) is nonzero. The exact word 0x00000013 sets only `canon_nop` and no HINT flag.
- R5: With rd = 0, these forms set `hint_std`: the immediate AND/OR/XOR (opcode 0010011, funct3 111/110/100), and the register ops on opcode 0110011 with funct7 (bits [31:25]) = 0000000 and funct3 000, 001, 100, 101, 110, 111, or with funct7 = 0100000 and funct3 000 or 101. Any other funct7 on opcode 0110011 sets nothing.
- R6: With rd = 0, these forms set `hint_custom`: the immediate set-less-than forms (opcode 0010011, funct3 010 and 011), the register set-less-than forms (opcode 0110011, funct7 0, funct3 010 and 011), and the immediate shifts (funct3 001 and 101).
- R7: An immediate shift is recognised only when bits [31:26] are 000000 (logical left or right) or 010000 (arithmetic right, funct3 101 only). When `WIDE_SHAMT` = 0, bit 25 must also be 0. A word that fails these checks sets no flag.
- R8: A fence (opcode 0001111, funct3 000) with fm (bits [31:28]) = 0, with pred (bits [27:24]) = 0 or succ (bits [23:20]) = 0, and with exactly one of rd and rs1 zero, sets `hint_std`.
- R9: A fence with fm = 0 and rd = rs1 = 0 follows these rules. pred = 0001 (write only) with succ = 0 is the pause, word 0x0100000F, and sets `hint_pause`. pred = 0 with succ ≠ 0 sets `hint_std`. pred not in {0, 0001} with succ = 0 sets `hint_std`. pred = succ = 0 sets nothing. Any fence with fm ≠ 0 sets nothing.
- R10: `hint_any` equals the OR of `hint_std`, `hint_custom` and `hint_pause`, and at most one of those three is high in any cycle.
- R11: A HINT candidate with rd ≠ 0, any other opcode, and a fence with funct3 ≠ 000 all leave every flag low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_instr` this cycle |
| in_instr | input | 32 | Instruction word to classify |
| hint_any | output | 1 | Encoding is a HINT of any group |
| hint_std | output | 1 | HINT held back for future standard use |
| hint_custom | output | 1 | HINT left for custom use |
| hint_pause | output | 1 | The pause code point |
| canon_nop | output | 1 | The canonical NOP word |

## Verification
The embedded properties check, on every cycle, the relation between the group flags and `hint_any` and the exclusivity of the groups. They also check that a cycle without `in_valid` clears the outputs one cycle later, that the pause word and the canonical NOP word land on their own flags, and that a nonzero destination outside the fence opcode never raises a HINT. Only the bench scenarios show the per-opcode carving. That covers the funct7 qualifiers on the register ops, the shift upper-bit patterns and the bit-25 rule. It also covers the full sweep of fence pred and succ values with zero registers, where the 0/0 case and the write-only case must fall apart from their neighbours.

// File: rtl/hint_classifier.sv
module hint_classifier #(
  parameter bit WIDE_SHAMT = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_instr,
  output logic        hint_any,
  output logic        hint_std,
  output logic        hint_custom,
  output logic        hint_pause,
  output logic        canon_nop
);

  localparam logic [6:0]  OPC_LUI   = 7'b0110111;
  localparam logic [6:0]  OPC_AUIPC = 7'b0010111;
  localparam logic [6:0]  OPC_IMM   = 7'b0010011;
  localparam logic [6:0]  OPC_REG   = 7'b0110011;
  localparam logic [6:0]  OPC_MEM   = 7'b0001111;
  localparam logic [3:0]  PRED_W    = 4'b0001;
  localparam logic [31:0] NOP_WORD  = 32'h0000_0013;
  localparam logic [31:0] PAUSE_WORD = 32'h0100_000F;

  logic [6:0]  opc;
  logic [4:0]  rd, rs1;
  logic [2:0]  f3;
  logic [6:0]  f7;
  logic [11:0] imm12;
  logic [5:0]  sh_top;
  logic [3:0]  fm, pred, succ;

  assign opc    = in_instr[6:0];
  assign rd     = in_instr[11:7];
  assign f3     = in_instr[14:12];
  assign rs1    = in_instr[19:15];
  assign f7     = in_instr[31:25];
  assign imm12  = in_instr[31:20];
  assign sh_top = in_instr[31:26];
  assign fm     = in_instr[31:28];
  assign pred   = in_instr[27:24];
  assign succ   = in_instr[23:20];

  logic rd0, rs10, shamt_ok;
  assign rd0  = (rd == 5'd0);
  assign rs10 = (rs1 == 5'd0);

  generate
    if (WIDE_SHAMT) begin : g_wide
      assign shamt_ok = 1'b1;
    end else begin : g_narrow
      assign shamt_ok = ~in_instr[25];
    end
  endgenerate

  logic upper_std, imm_std, imm_cust, reg_std, reg_cust;
  logic is_fence, fence_std, fence_pause;

  assign upper_std = (opc == OPC_LUI) || (opc == OPC_AUIPC);

  always_comb begin
    imm_std  = 1'b0;
    imm_cust = 1'b0;
    if (opc == OPC_IMM) begin
      unique case (f3)
        3'b000:                   imm_std  = !(rs10 && imm12 == 12'd0);
        3'b100, 3'b110, 3'b111:   imm_std  = 1'b1;
        3'b010, 3'b011:           imm_cust = 1'b1;
        3'b001:                   imm_cust = (sh_top == 6'b000000) && shamt_ok;
        3'b101:                   imm_cust = ((sh_top == 6'b000000) || (sh_top == 6'b010000)) && shamt_ok;
        default:                  imm_cust = 1'b0;
      endcase
    end
  end

  always_comb begin
    reg_std  = 1'b0;
    reg_cust = 1'b0;
    if (opc == OPC_REG) begin
      if (f7 == 7'b0000000) begin
        reg_cust = (f3 == 3'b010) || (f3 == 3'b011);
        reg_std  = !reg_cust;
      end else if (f7 == 7'b0100000) begin
        reg_std  = (f3 == 3'b000) || (f3 == 3'b101);
      end
    end
  end

  assign is_fence = (opc == OPC_MEM) && (f3 == 3'b000) && (fm == 4'd0);

  always_comb begin
    fence_std   = 1'b0;
    fence_pause = 1'b0;
    if (is_fence) begin
      if (rd0 ^ rs10) begin
        fence_std = (pred == 4'd0) || (succ == 4'd0);
      end else if (rd0 && rs10) begin
        if (pred == 4'd0)
          fence_std = (succ != 4'd0);
        else if (succ == 4'd0) begin
          fence_pause = (pred == PRED_W);
          fence_std   = (pred != PRED_W);
        end
      end
    end
  end

  logic std_d, cust_d, nop_d;
  assign std_d  = (rd0 && (upper_std || imm_std || reg_std)) || fence_std;
  assign cust_d = rd0 && (imm_cust || reg_cust);
  assign nop_d  = (in_instr == NOP_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hint_any    <= 1'b0;
      hint_std    <= 1'b0;
      hint_custom <= 1'b0;
      hint_pause  <= 1'b0;
      canon_nop   <= 1'b0;
    end else begin
      hint_any    <= in_valid && (std_d || cust_d || fence_pause);
      hint_std    <= in_valid && std_d;
      hint_custom <= in_valid && cust_d;
      hint_pause  <= in_valid && fence_pause;
      canon_nop   <= in_valid && nop_d;
    end
  end

  p_any_is_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hint_any == (hint_std | hint_custom | hint_pause));

  p_one_group_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hint_std, hint_custom, hint_pause}) <= 1);

  p_idle_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !(hint_any | hint_std | hint_custom | hint_pause | canon_nop));

  p_pause_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr == PAUSE_WORD) |=> (hint_pause && !hint_std));

  p_nop_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr == NOP_WORD) |=> (canon_nop && !hint_any));

  p_rd_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_instr[11:7] != 5'd0 && in_instr[6:0] != OPC_MEM) |=> !hint_any);

endmodule

// File: tb/hint_classifier_test.sv
module hint_classifier_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_instr = 32'd0;
  logic hint_any, hint_std, hint_custom, hint_pause, canon_nop;

  always #4 clk = ~clk;

  hint_classifier uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
    .hint_any(hint_any), .hint_std(hint_std), .hint_custom(hint_custom),
    .hint_pause(hint_pause), .canon_nop(canon_nop)
  );

  typedef struct {
    logic [31:0] ins;
    logic [3:0]  exp;
    string       tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [3:0] E_NONE = 4'b0000;
  localparam logic [3:0] E_STD  = 4'b1000;
  localparam logic [3:0] E_CUST = 4'b0100;
  localparam logic [3:0] E_PAUS = 4'b0010;
  localparam logic [3:0] E_NOP  = 4'b0001;

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd,
                                        input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction

  function automatic logic [31:0] enc_f(input logic [3:0] fm, input logic [3:0] pr,
                                        input logic [3:0] su, input logic [4:0] rs1,
                                        input logic [4:0] rd);
    return {fm, pr, su, rs1, 3'b000, rd, 7'b0001111};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] ins, input logic [3:0] e, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = v;
    in_instr = ins;
    it.ins = ins;
    it.exp = v ? e : E_NONE;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic send(input logic [31:0] ins, input logic [3:0] e, input string tag);
    drive(1'b1, ins, e, tag);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(it.tag, {28'd0, hint_std, hint_custom, hint_pause, canon_nop}, {28'd0, it.exp});
        check("R10 any", {31'd0, hint_any}, {31'd0, (it.exp[3] | it.exp[2] | it.exp[1])});
        check("R10 excl", {31'd0, ($countones({hint_std, hint_custom, hint_pause}) <= 1)}, 32'd1);
      end
    end
  end

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : driver
    logic [3:0] e;
    repeat (3) @(negedge clk);
    check("R1 reset", {27'd0, hint_any, hint_std, hint_custom, hint_pause, canon_nop}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1 after reset", {27'd0, hint_any, hint_std, hint_custom, hint_pause, canon_nop}, 32'd0);

    send(32'h1234_5037, E_STD,  "R3 lui rd0");
    send(32'h1234_52B7, E_NONE, "R11 lui rd5");
    send(32'h0000_1017, E_STD,  "R3 auipc rd0");
    send(32'h0000_0013, E_NOP,  "R4 canonical nop");
    send(enc_i(12'd1, 5'd0, 3'b000, 5'd0, 7'b0010011), E_STD,  "R4 addi imm1");
    send(enc_i(12'd0, 5'd1, 3'b000, 5'd0, 7'b0010011), E_STD,  "R4 addi rs1");
    send(enc_i(12'd0, 5'd0, 3'b000, 5'd1, 7'b0010011), E_NONE, "R11 addi rd1");
    drive(1'b0, 32'h0000_0013, E_NOP, "R2 invalid nop");
    drive(1'b0, 32'h0100_000F, E_PAUS, "R2 invalid pause");
    send(enc_i(12'h0FF, 5'd3, 3'b111, 5'd0, 7'b0010011), E_STD, "R5 andi");
    send(enc_i(12'h800, 5'd3, 3'b110, 5'd0, 7'b0010011), E_STD, "R5 ori");
    send(enc_i(12'h7FF, 5'd0, 3'b100, 5'd0, 7'b0010011), E_STD, "R5 xori");
    for (int f = 0; f < 8; f++) begin
      e = (f == 2 || f == 3) ? E_CUST : E_STD;
      send(enc_r(7'b0000000, 5'd2, 5'd1, f[2:0], 5'd0), e, "R5 R6 reg f7=0");
      send(enc_r(7'b0100000, 5'd2, 5'd1, f[2:0], 5'd0),
           (f == 0 || f == 5) ? E_STD : E_NONE, "R5 reg f7=0100000");
      send(enc_r(7'b0000001, 5'd2, 5'd1, f[2:0], 5'd0), E_NONE, "R5 other f7");
      send(enc_r(7'b0000000, 5'd2, 5'd1, f[2:0], 5'd4), E_NONE, "R11 reg rd4");
    end
    send(enc_i(12'h005, 5'd1, 3'b010, 5'd0, 7'b0010011), E_CUST, "R6 slti");
    send(enc_i(12'hFFF, 5'd1, 3'b011, 5'd0, 7'b0010011), E_CUST, "R6 sltiu");
    send(enc_i(12'h005, 5'd1, 3'b001, 5'd0, 7'b0010011), E_CUST, "R6 slli");
    send(enc_i(12'h01F, 5'd1, 3'b101, 5'd0, 7'b0010011), E_CUST, "R6 srli");
    send(enc_i(12'h403, 5'd1, 3'b101, 5'd0, 7'b0010011), E_CUST, "R7 srai 010000");
    send(enc_i(12'h803, 5'd1, 3'b101, 5'd0, 7'b0010011), E_NONE, "R7 srai 100000");
    send(enc_i(12'h403, 5'd1, 3'b001, 5'd0, 7'b0010011), E_NONE, "R7 slli 010000");
    send(enc_i(12'h020, 5'd1, 3'b001, 5'd0, 7'b0010011), E_NONE, "R7 slli bit25");
    send(enc_i(12'h423, 5'd1, 3'b101, 5'd0, 7'b0010011), E_NONE, "R7 srai bit25");
    send(enc_i(12'h403, 5'd1, 3'b101, 5'd2, 7'b0010011), E_NONE, "R11 srai rd2");

    send(enc_f(4'd0, 4'd3, 4'd0, 5'd0, 5'd1), E_STD,  "R8 rd only succ0");
    send(enc_f(4'd0, 4'd0, 4'd5, 5'd6, 5'd0), E_STD,  "R8 rs1 only pred0");
    send(enc_f(4'd0, 4'd3, 4'd3, 5'd0, 5'd1), E_NONE, "R8 both nonzero sets");
    send(enc_f(4'd0, 4'd0, 4'd0, 5'd2, 5'd1), E_NONE, "R8 both regs");
    send(enc_f(4'd8, 4'd0, 4'd3, 5'd0, 5'd1), E_NONE, "R9 fm nonzero one reg");
    send(32'h0100_000F, E_PAUS, "R9 pause word");
    send(enc_f(4'd8, 4'd1, 4'd0, 5'd0, 5'd0), E_NONE, "R9 pause fm8");
    send(32'h0100_100F, E_NONE, "R11 fence funct3 001");
    for (int p = 0; p < 16; p++) begin
      for (int s = 0; s < 16; s++) begin
        if (p == 1 && s == 0)      e = E_PAUS;
        else if (p == 0 && s == 0) e = E_NONE;
        else if (p == 0 || s == 0) e = E_STD;
        else                       e = E_NONE;
        send(enc_f(4'd0, p[3:0], s[3:0], 5'd0, 5'd0), e, "R9 zero-reg fence sweep");
      end
    end
    send(32'h0000_0033, E_STD, "R5 add x0 x0 x0");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 queue drained", q.size(), 32'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule